// File: doc/BRIEF.md
# Scan-Loaded Debug Watchpoint Unit

This block holds a small debug register file and two watchpoint comparators. Every register is reached through one 38-bit serial scan register, shifted one bit per clock while `shift_en` is high. The scan word carries a 32-bit data field in bits 31:0, a 5-bit register address in bits 36:32 and a direction bit in bit 37 (1 = write, 0 = read). Bits enter at bit 37 and leave from bit 0, so the data field's least significant bit is shifted out first.

A one-cycle `update_en` pulse commits the word. For a write, the data field goes into the addressed register. For a read, the addressed register's value is zero-extended and loaded into the data field, ready to be shifted out. Each watchpoint compares the bus address, bus data and an 8-bit control vector against its value registers. Mask bits exclude positions from the compare. A registered breakpoint line rises when every compare agrees and the watchpoint is enabled.

Register map (5-bit address): 0x00 debug control (3 bits), 0x01 debug status (5 bits, read-only), 0x04 link control (6 bits), 0x05 link data (32 bits). Watchpoint 0 occupies 0x08 to 0x0D and watchpoint 1 occupies 0x10 to 0x15. Within each watchpoint the offsets are: +0 address value, +1 address mask, +2 data value, +3 data mask, +4 control value (9 bits, bit 8 = enable), +5 control mask (8 bits).

Top module: `dbg_watch_unit`

## Requirements
- R1: While reset is asserted and right after it, every register reads zero, `scan_out` is 0 and `bkpt_o` is 0.
- R2: Each clock with `shift_en` high moves the scan register one place toward bit 0, takes `scan_in` into bit 37 and presents bit 0 on `scan_out`. Shifting any 38-bit word in and then 38 more bits returns that word on `scan_out`, bit 0 first. With neither enable high, the scan register holds its value.
- R3: An `update_en` pulse with bit 37 = 1 writes bits 31:0 into the register at address bits 36:32, and the new value is visible from the next clock. No register changes without such a write.
- R4: An `update_en` pulse with bit 37 = 0 replaces scan bits 31:0 with the addressed register's value at the next clock.
- R5: A read of any address outside the map returns zero. A write to such an address changes no register.
- R6: A register narrower than 32 bits keeps only the low bits of a write and reads back zero above its width.
- R7: The status register at 0x01 reads the current breakpoint lines in bits 1:0 and zero above them. Writes to it are ignored.
- R8: `bkpt_o[n]` is high one clock after the bus inputs match watchpoint n's address, data and control values at every unmasked bit.
- R9: A mask bit of 1 makes that bit position a don't-care for its compare.
- R10: A watchpoint whose control value bit 8 is clear never raises its breakpoint.
- R11: The two watchpoints are configured and evaluated independently, at the addresses and offsets given in the map.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_en | input | 1 | Shift the scan register one bit this cycle |
| update_en | input | 1 | Commit the scan word (write or read load) |
| scan_in | input | 1 | Serial data into scan bit 37 |
| scan_out | output | 1 | Serial data from scan bit 0 |
| bus_addr | input | 32 | Observed bus address |
| bus_data | input | 32 | Observed bus data |
| bus_ctrl | input | 8 | Observed bus control vector |
| bkpt_o | output | 2 | Registered breakpoint per watchpoint |

## Verification
The assertions assume that `shift_en` and `update_en` are never high in the same cycle, and that an update is a single-cycle pulse issued only after a complete 38-bit word has been shifted in. The bench drives all scan traffic through tasks that shift exactly 38 bits, raise the update for one cycle and lower every enable between operations. Bus inputs change only on the falling edge, and each change is held for a full cycle before the breakpoint lines are compared.

// File: rtl/dwu_pkg.sv
package dwu_pkg;

    localparam int DATA_W = 32;
    localparam int RADR_W = 5;
    localparam int SCAN_W = DATA_W + RADR_W + 1;
    localparam int CTRL_W = 8;
    localparam int DBGC_W = 3;
    localparam int STAT_W = 5;
    localparam int LNKC_W = 6;

    localparam logic [RADR_W-1:0] ADR_DBG_CTRL = 5'h00;
    localparam logic [RADR_W-1:0] ADR_DBG_STAT = 5'h01;
    localparam logic [RADR_W-1:0] ADR_LNK_CTRL = 5'h04;
    localparam logic [RADR_W-1:0] ADR_LNK_DATA = 5'h05;

    // Offsets inside one watchpoint group of eight addresses
    localparam logic [2:0] OFS_AVAL = 3'd0;
    localparam logic [2:0] OFS_AMSK = 3'd1;
    localparam logic [2:0] OFS_DVAL = 3'd2;
    localparam logic [2:0] OFS_DMSK = 3'd3;
    localparam logic [2:0] OFS_CVAL = 3'd4;
    localparam logic [2:0] OFS_CMSK = 3'd5;

    typedef struct packed {
        logic [DATA_W-1:0] aval;
        logic [DATA_W-1:0] amsk;
        logic [DATA_W-1:0] dval;
        logic [DATA_W-1:0] dmsk;
        logic [CTRL_W:0]   cval;   // top bit is the enable
        logic [CTRL_W-1:0] cmsk;
    } wp_cfg_t;

    typedef struct packed {
        logic [DBGC_W-1:0] dbg_ctrl;
        logic [LNKC_W-1:0] lnk_ctrl;
        logic [DATA_W-1:0] lnk_data;
    } misc_regs_t;

    function automatic logic addr_mapped(logic [RADR_W-1:0] a, int nwp);
        logic hit;
        hit = (a == ADR_DBG_CTRL) || (a == ADR_DBG_STAT) ||
              (a == ADR_LNK_CTRL) || (a == ADR_LNK_DATA);
        for (int i = 0; i < nwp; i++) begin
            if ((int'(a[RADR_W-1:3]) == i + 1) && (a[2:0] <= OFS_CMSK)) hit = 1'b1;
        end
        return hit;
    endfunction

endpackage

// File: rtl/dwu_scan_chain.sv
module dwu_scan_chain #(
    parameter int DATA_W = 32,
    parameter int RADR_W = 5,
    localparam int SCAN_W = DATA_W + RADR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              scan_in,
    input  logic              load_en,
    input  logic [DATA_W-1:0] load_data,
    output logic              scan_out,
    output logic [SCAN_W-1:0] word_o
);

    typedef struct packed {
        logic [SCAN_W-1:0] sr;
    } chain_t;

    chain_t chain_d, chain_q;

    always_comb begin
        chain_d = chain_q;
        if (shift_en) begin
            chain_d.sr = {scan_in, chain_q.sr[SCAN_W-1:1]};
        end else if (load_en) begin
            chain_d.sr[DATA_W-1:0] = load_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign scan_out = chain_q.sr[0];
    assign word_o   = chain_q.sr;

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && !load_en) |=> $stable(word_o)); // R2

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(shift_en && load_en)); // R2

endmodule

// File: rtl/dwu_regfile.sv
module dwu_regfile
    import dwu_pkg::*;
#(
    parameter int NUM_WP = 2,
    localparam int GRP_W = RADR_W - 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [RADR_W-1:0]       wr_addr,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic [RADR_W-1:0]       rd_addr,
    output logic [DATA_W-1:0]       rd_data,
    input  logic [STAT_W-1:0]       stat_i,
    output wp_cfg_t [NUM_WP-1:0]    wp_cfg_o
);

    misc_regs_t             misc_d, misc_q;
    wp_cfg_t [NUM_WP-1:0]   wp_d, wp_q;

    always_comb begin
        misc_d = misc_q;
        wp_d   = wp_q;
        if (wr_en) begin
            case (wr_addr)
                ADR_DBG_CTRL: misc_d.dbg_ctrl = wr_data[DBGC_W-1:0];
                ADR_LNK_CTRL: misc_d.lnk_ctrl = wr_data[LNKC_W-1:0];
                ADR_LNK_DATA: misc_d.lnk_data = wr_data;
                default: ;
            endcase
            for (int i = 0; i < NUM_WP; i++) begin
                if (wr_addr[RADR_W-1:3] == GRP_W'(i + 1)) begin
                    case (wr_addr[2:0])
                        OFS_AVAL: wp_d[i].aval = wr_data;
                        OFS_AMSK: wp_d[i].amsk = wr_data;
                        OFS_DVAL: wp_d[i].dval = wr_data;
                        OFS_DMSK: wp_d[i].dmsk = wr_data;
                        OFS_CVAL: wp_d[i].cval = wr_data[CTRL_W:0];
                        OFS_CMSK: wp_d[i].cmsk = wr_data[CTRL_W-1:0];
                        default: ;
                    endcase
                end
            end
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADR_DBG_CTRL: rd_data = DATA_W'(misc_q.dbg_ctrl);
            ADR_DBG_STAT: rd_data = DATA_W'(stat_i);
            ADR_LNK_CTRL: rd_data = DATA_W'(misc_q.lnk_ctrl);
            ADR_LNK_DATA: rd_data = misc_q.lnk_data;
            default: ;
        endcase
        for (int i = 0; i < NUM_WP; i++) begin
            if (rd_addr[RADR_W-1:3] == GRP_W'(i + 1)) begin
                case (rd_addr[2:0])
                    OFS_AVAL: rd_data = wp_q[i].aval;
                    OFS_AMSK: rd_data = wp_q[i].amsk;
                    OFS_DVAL: rd_data = wp_q[i].dval;
                    OFS_DMSK: rd_data = wp_q[i].dmsk;
                    OFS_CVAL: rd_data = DATA_W'(wp_q[i].cval);
                    OFS_CMSK: rd_data = DATA_W'(wp_q[i].cmsk);
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            misc_q <= '0;
            wp_q   <= '0;
        end else begin
            misc_q <= misc_d;
            wp_q   <= wp_d;
        end
    end

    assign wp_cfg_o = wp_q;

    AST_REGS_NEED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(misc_q) && $stable(wp_q))); // R3

    AST_UNMAPPED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr_mapped(wr_addr, NUM_WP)) |=> ($stable(misc_q) && $stable(wp_q))); // R5

    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == ADR_DBG_CTRL) |-> (rd_data[DATA_W-1:DBGC_W] == '0)); // R6

endmodule

// File: rtl/dwu_watch_cmp.sv
module dwu_watch_cmp
    import dwu_pkg::*;
(
    input  wp_cfg_t           cfg,
    input  logic [DATA_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic [CTRL_W-1:0] bus_ctrl,
    output logic              hit
);

    logic addr_ok, data_ok, ctrl_ok;

    always_comb begin
        addr_ok = ((bus_addr ^ cfg.aval) & ~cfg.amsk) == '0;
        data_ok = ((bus_data ^ cfg.dval) & ~cfg.dmsk) == '0;
        ctrl_ok = ((bus_ctrl ^ cfg.cval[CTRL_W-1:0]) & ~cfg.cmsk) == '0;
        hit     = cfg.cval[CTRL_W] && addr_ok && data_ok && ctrl_ok;
    end

endmodule

// File: rtl/dbg_watch_unit.sv
module dbg_watch_unit
    import dwu_pkg::*;
#(
    parameter int NUM_WP = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              update_en,
    input  logic              scan_in,
    output logic              scan_out,
    input  logic [31:0]       bus_addr,
    input  logic [31:0]       bus_data,
    input  logic [7:0]        bus_ctrl,
    output logic [NUM_WP-1:0] bkpt_o
);

    logic [SCAN_W-1:0]     word;
    logic                  wr_en, load_en;
    logic [RADR_W-1:0]     reg_addr;
    logic [DATA_W-1:0]     rd_data;
    wp_cfg_t [NUM_WP-1:0]  wp_cfg;
    logic [NUM_WP-1:0]     hit;

    typedef struct packed {
        logic [NUM_WP-1:0] bkpt;
    } top_state_t;

    top_state_t st_d, st_q;

    assign reg_addr = word[SCAN_W-2:DATA_W];
    assign wr_en    = update_en &&  word[SCAN_W-1];
    assign load_en  = update_en && !word[SCAN_W-1];

    dwu_scan_chain #(.DATA_W(DATA_W), .RADR_W(RADR_W)) chain_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (shift_en),
        .scan_in   (scan_in),
        .load_en   (load_en),
        .load_data (rd_data),
        .scan_out  (scan_out),
        .word_o    (word)
    );

    dwu_regfile #(.NUM_WP(NUM_WP)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (reg_addr),
        .wr_data  (word[DATA_W-1:0]),
        .rd_addr  (reg_addr),
        .rd_data  (rd_data),
        .stat_i   (STAT_W'(st_q.bkpt)),
        .wp_cfg_o (wp_cfg)
    );

    for (genvar g = 0; g < NUM_WP; g++) begin : g_wp
        dwu_watch_cmp cmp_i (
            .cfg      (wp_cfg[g]),
            .bus_addr (bus_addr),
            .bus_data (bus_data),
            .bus_ctrl (bus_ctrl),
            .hit      (hit[g])
        );

        AST_BKPT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
            bkpt_o[g] |-> $past(wp_cfg[g].cval[CTRL_W])); // R10
    end

    always_comb begin
        st_d      = st_q;
        st_d.bkpt = hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bkpt_o = st_q.bkpt;

    AST_STATUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && reg_addr == ADR_DBG_STAT) |=> (word[DATA_W-1:0] == DATA_W'($past(bkpt_o)))); // R7

endmodule

// File: tb/dbg_watch_unit_tb_top.sv
module dbg_watch_unit_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        shift_en = 1'b0;
    logic        update_en = 1'b0;
    logic        scan_in = 1'b0;
    logic        scan_out;
    logic [31:0] bus_addr = '0;
    logic [31:0] bus_data = '0;
    logic [7:0]  bus_ctrl = '0;
    logic [1:0]  bkpt_o;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_watch_unit dut_i (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .update_en(update_en),
        .scan_in(scan_in), .scan_out(scan_out), .bus_addr(bus_addr),
        .bus_data(bus_data), .bus_ctrl(bus_ctrl), .bkpt_o(bkpt_o)
    );

    task automatic chk(input string req, input logic [37:0] act, input logic [37:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic shift_bit(input logic b, output logic o);
        o        = scan_out;
        scan_in  = b;
        shift_en = 1'b1;
        @(negedge clk);
        shift_en = 1'b0;
    endtask

    task automatic put_word(input logic rw, input logic [4:0] a, input logic [31:0] d);
        logic [37:0] w;
        logic o;
        w = {rw, a, d};
        for (int i = 0; i < 38; i++) shift_bit(w[i], o);
        update_en = 1'b1;
        @(negedge clk);
        update_en = 1'b0;
    endtask

    task automatic reg_wr(input logic [4:0] a, input logic [31:0] d);
        put_word(1'b1, a, d);
    endtask

    task automatic reg_rd(input logic [4:0] a, output logic [31:0] v);
        logic o;
        put_word(1'b0, a, 32'h0);
        for (int i = 0; i < 32; i++) begin
            shift_bit(1'b0, o);
            v[i] = o;
        end
    endtask

    task automatic set_bus(input logic [31:0] a, input logic [31:0] d, input logic [7:0] c);
        bus_addr = a;
        bus_data = d;
        bus_ctrl = c;
        @(negedge clk);
    endtask

    // Width of each mapped register; 0 = unmapped; status handled apart
    function automatic int reg_width(input int a);
        case (a)
            0:               return 3;
            4:               return 6;
            5:               return 32;
            8, 9, 10, 11:    return 32;
            16, 17, 18, 19:  return 32;
            12, 20:          return 9;
            13, 21:          return 8;
            default:         return 0;
        endcase
    endfunction

    function automatic logic [31:0] width_mask(input int w);
        return (w >= 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
    endfunction

    function automatic logic [31:0] pattern(input int a);
        return 32'h9E37_79B9 * (a + 1) ^ 32'h5A5A_0F0F;
    endfunction

    localparam logic [31:0] WA = 32'h1000_0040;
    localparam logic [31:0] WD = 32'hDEAD_BEEF;
    localparam logic [7:0]  WC = 8'h05;

    initial begin
        logic [31:0] v;
        logic [37:0] w;
        logic o;

        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 scan_out", 38'(scan_out), 38'h0);
        chk("R1 bkpt", 38'(bkpt_o), 38'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 scan_out after release", 38'(scan_out), 38'h0);
        for (int a = 0; a < 32; a++) begin
            reg_rd(5'(a), v);
            chk($sformatf("R1 reset read addr %0d", a), 38'(v), 38'h0);
        end

        // R2: pure pass-through of a 38-bit word, bit 0 first
        w = 38'h2A_C3F0_5A1E;
        for (int i = 0; i < 38; i++) shift_bit(w[i], o);
        for (int i = 0; i < 38; i++) begin
            shift_bit(1'b0, o);
            chk($sformatf("R2 passthrough bit %0d", i), 38'(o), 38'(w[i]));
        end
        // R2: idle cycles keep the word in place
        for (int i = 0; i < 38; i++) shift_bit(w[i], o);
        repeat (5) @(negedge clk);
        for (int i = 0; i < 38; i++) begin
            shift_bit(1'b0, o);
            chk($sformatf("R2 hold bit %0d", i), 38'(o), 38'(w[i]));
        end

        // R3 R4 R5 R6: write every address, then read every address back
        for (int a = 0; a < 32; a++) reg_wr(5'(a), pattern(a));
        for (int a = 0; a < 32; a++) begin
            reg_rd(5'(a), v);
            if (a == 1)
                chk("R7 status after sweep", 38'(v), 38'(bkpt_o));
            else
                chk($sformatf("R3 R4 R5 R6 sweep addr %0d", a), 38'(v),
                    38'(pattern(a) & width_mask(reg_width(a))));
        end

        // R7: status write ignored, reads breakpoint lines
        reg_wr(5'h0C, 32'h0);
        reg_wr(5'h14, 32'h0);
        @(negedge clk);
        reg_wr(5'h01, 32'hFFFF_FFFF);
        reg_rd(5'h01, v);
        chk("R7 status with no breakpoints", 38'(v), 38'h0);

        // R8 R9 R11: configure watchpoint 0
        reg_wr(5'h08, WA);
        reg_wr(5'h09, 32'h0000_000F);
        reg_wr(5'h0A, WD);
        reg_wr(5'h0B, 32'hFFFF_0000);
        reg_wr(5'h0D, 32'h0000_00F0);
        reg_wr(5'h0C, {23'h0, 1'b1, WC});
        set_bus(WA, WD, WC);
        chk("R8 exact match", 38'(bkpt_o), 38'h1);
        reg_rd(5'h01, v);
        chk("R7 status shows wp0", 38'(v), 38'h1);
        set_bus(32'h1000_004A, 32'h1234_BEEF, 8'h35);
        chk("R9 masked bits ignored", 38'(bkpt_o), 38'h1);
        for (int b = 0; b < 32; b++) begin
            set_bus(WA ^ (32'h1 << b), WD, WC);
            chk($sformatf("R9 addr bit %0d", b), 38'(bkpt_o), (b < 4) ? 38'h1 : 38'h0);
        end
        for (int b = 0; b < 32; b++) begin
            set_bus(WA, WD ^ (32'h1 << b), WC);
            chk($sformatf("R9 data bit %0d", b), 38'(bkpt_o), (b >= 16) ? 38'h1 : 38'h0);
        end
        for (int b = 0; b < 8; b++) begin
            set_bus(WA, WD, WC ^ (8'h1 << b));
            chk($sformatf("R9 ctrl bit %0d", b), 38'(bkpt_o), (b >= 4) ? 38'h1 : 38'h0);
        end
        // R8: output is registered one clock after the bus
        bus_addr = 32'h0;
        #1;
        chk("R8 registered output holds", 38'(bkpt_o), 38'h1);
        @(negedge clk);
        chk("R8 output drops next clock", 38'(bkpt_o), 38'h0);

        // R11: watchpoint 1 matches everything once enabled
        reg_wr(5'h11, 32'hFFFF_FFFF);
        reg_wr(5'h13, 32'hFFFF_FFFF);
        reg_wr(5'h15, 32'h0000_00FF);
        set_bus(32'h0, 32'h0, 8'h0);
        chk("R11 wp1 still disabled", 38'(bkpt_o), 38'h0);
        reg_wr(5'h14, 32'h0000_0100);
        set_bus(32'hFFFF_0000, 32'h1357_9BDF, 8'hAA);
        chk("R11 wp1 alone", 38'(bkpt_o), 38'h2);
        set_bus(WA, WD, WC);
        chk("R11 both", 38'(bkpt_o), 38'h3);
        reg_rd(5'h01, v);
        chk("R7 status shows both", 38'(v), 38'h3);

        // R10: clearing the enable bit kills the match
        reg_wr(5'h0C, {23'h0, 1'b0, WC});
        set_bus(WA, WD, WC);
        chk("R10 wp0 disabled", 38'(bkpt_o), 38'h2);
        reg_wr(5'h14, 32'h0000_00FF);
        set_bus(WA, WD, WC);
        chk("R10 wp1 disabled", 38'(bkpt_o), 38'h0);

        // R5: unmapped write leaves neighbours intact
        reg_wr(5'h0E, 32'hFFFF_FFFF);
        reg_wr(5'h16, 32'hFFFF_FFFF);
        reg_rd(5'h0D, v);
        chk("R5 neighbour 0x0D intact", 38'(v), 38'h0F0);
        reg_rd(5'h0E, v);
        chk("R5 unmapped reads zero", 38'(v), 38'h0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule